// File: doc/BRIEF.md
# Wormhole Mesh Packet Router

A single router tile for a two-dimensional mesh network-on-chip. It sits at a fixed coordinate in a grid of `MESH_W` by `MESH_H` nodes. It builds only the links that exist at that coordinate: the local link always, plus a north, south, east and west link where a neighbour is present. Each built input has a flit queue. The router reads the header flit at the head of each queue, picks an output by dimension-ordered routing, and arbitrates each output round-robin among the inputs that want it.

Switching is wormhole. When a header wins an output, that output stays with the packet until the number of body flits announced in the header has passed. Flits from another input cannot interleave with them. The routing order, X then Y or Y then X, is fixed by a parameter. A second parameter selects cut-through admission, in which an input accepts a new header only while its queue has room for a whole packet.

Top module: `noc_router`

## Requirements
- R1: Port index 0 is local, 1 north (y+1), 2 south (y-1), 3 east (x+1), 4 west (x-1). A direction with no neighbour at (`POS_X`,`POS_Y`) is not built: its `in_ready` bit and its `out_valid` bit stay 0.
- R2: With `ROUTE_YX`=0, a header whose destination column differs from `POS_X` leaves east or west. Only when the column matches does it leave north or south.
- R3: With `ROUTE_YX`=1, the row is resolved first (north/south), then the column (east/west).
- R4: Node numbers are y*`MESH_W`+x. A header whose destination equals the router's own number leaves on the local port.
- R5: After a header is granted an output, that output carries only the flits of that packet until its last flit, with no flit from another input in between.
- R6: A header flit carries destination in bits [9:0], source in [19:10] and a body-flit count of 0 to 7 in [22:20]. A packet is the header plus exactly that many body flits, and every flit is forwarded unchanged.
- R7: When several inputs hold headers for one free output, grants rotate round-robin. The latest winner gets the lowest priority next.
- R8: A flit moves on a link only in a cycle with both valid and ready high. A stalled output keeps its valid and data unchanged.
- R9: Packets entering on one input for one output leave in the order they entered.
- R10: With `CUT_THROUGH`=1, an input accepts a header only while its queue has room for 8 flits. Body flits of a packet already started are accepted whenever the queue is not full.
- R11: Reset empties every queue, clears all outputs and releases every output lock: after reset all outputs are invalid and every built input is ready.
- R12: With `CUT_THROUGH`=0, an input drops `in_ready` once its queue holds `FIFO_DEPTH` flits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | Per input port: flit offered |
| in_data | input | 5*FLIT_W | Per input port: flit, port p at bits [p*FLIT_W +: FLIT_W] |
| in_ready | output | 5 | Per input port: flit accepted this cycle if valid |
| out_valid | output | 5 | Per output port: registered flit present |
| out_data | output | 5*FLIT_W | Per output port: registered flit |
| out_ready | input | 5 | Per output port: downstream accepts the flit |

## Verification
The hardest situation to reach is an output stall at the exact moment queues are nearly full. Cut-through admission and full-queue back-pressure only show in that state. The bench holds one output's ready low while it streams two maximum-length packets into a single input. It then counts how many flits were accepted before `in_ready` dropped, and it checks the queue state just before and after the final body flit. Round-robin order and wormhole locking are driven the same way: two inputs are filled behind a stalled output, then the output is released.

// File: rtl/noc_pkg.sv
package noc_pkg;
  localparam int NPORT    = 5;
  localparam int P_LOCAL  = 0;
  localparam int P_NORTH  = 1;
  localparam int P_SOUTH  = 2;
  localparam int P_EAST   = 3;
  localparam int P_WEST   = 4;
  localparam int NODE_W   = 10;
  localparam int CNT_W    = 3;
  localparam int DST_LSB  = 0;
  localparam int SRC_LSB  = 10;
  localparam int CNT_LSB  = 20;
  localparam int HDR_BITS = 23;
  localparam int MAX_BODY = 7;

  function automatic logic [NODE_W-1:0] hdr_dst(input logic [HDR_BITS-1:0] h);
    return h[DST_LSB +: NODE_W];
  endfunction

  function automatic logic [CNT_W-1:0] hdr_cnt(input logic [HDR_BITS-1:0] h);
    return h[CNT_LSB +: CNT_W];
  endfunction
endpackage

// File: rtl/flit_fifo.sv
module flit_fifo
  import noc_pkg::*;
#(
  parameter int W       = 36,
  parameter int DEPTH   = 8,
  parameter bit CT      = 1'b0,
  parameter int MAX_PKT = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  input  logic         rd_pop,
  output logic [W-1:0] rd_data,
  output logic         rd_empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt, free;
  logic [CNT_W-1:0] wr_left;
  logic             full, push, pop;

  assign full     = (cnt == CW'(DEPTH));
  assign free     = CW'(DEPTH) - cnt;
  assign wr_ready = (CT && wr_left == '0) ? (free >= CW'(MAX_PKT)) : !full;
  assign push     = wr_valid & wr_ready;
  assign rd_empty = (cnt == '0);
  assign pop      = rd_pop & ~rd_empty;
  assign rd_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      wr_left <= '0;
    end else begin
      if (push) begin
        wp      <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        wr_left <= (wr_left == '0) ? hdr_cnt(wr_data[HDR_BITS-1:0]) : wr_left - 1'b1;
      end
      if (pop) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  // R12
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(DEPTH));
  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst) rd_pop |-> !rd_empty);
endmodule

// File: rtl/route_unit.sv
module route_unit
  import noc_pkg::*;
#(
  parameter int MESH_W = 4,
  parameter int POS_X  = 0,
  parameter int POS_Y  = 0,
  parameter bit YX     = 1'b0
) (
  input  logic [NODE_W-1:0] dst,
  output logic [NPORT-1:0]  port_oh
);
  logic [NODE_W-1:0] dx, dy;
  logic go_e, go_w, go_n, go_s;

  assign dx   = dst % NODE_W'(MESH_W);
  assign dy   = dst / NODE_W'(MESH_W);
  assign go_e = dx > NODE_W'(POS_X);
  assign go_w = dx < NODE_W'(POS_X);
  assign go_n = dy > NODE_W'(POS_Y);
  assign go_s = dy < NODE_W'(POS_Y);

  generate
    if (YX) begin : g_yx
      always_comb begin
        port_oh = '0;
        if (go_n)      port_oh[P_NORTH] = 1'b1;
        else if (go_s) port_oh[P_SOUTH] = 1'b1;
        else if (go_e) port_oh[P_EAST]  = 1'b1;
        else if (go_w) port_oh[P_WEST]  = 1'b1;
        else           port_oh[P_LOCAL] = 1'b1;
      end
    end else begin : g_xy
      always_comb begin
        port_oh = '0;
        if (go_e)      port_oh[P_EAST]  = 1'b1;
        else if (go_w) port_oh[P_WEST]  = 1'b1;
        else if (go_n) port_oh[P_NORTH] = 1'b1;
        else if (go_s) port_oh[P_SOUTH] = 1'b1;
        else           port_oh[P_LOCAL] = 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         advance,
  output logic [N-1:0] grant
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q;

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last_q) + k) % N;
      if (!found && req[idx]) begin
        grant[idx] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= IW'(N - 1);
    end else if (advance) begin
      for (int i = 0; i < N; i++) begin
        if (grant[i]) last_q <= IW'(i);
      end
    end
  end

  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && ((grant & ~req) == '0));
  // R7
  grant_rotates_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && $countones(req) > 1) |=> (grant != $past(grant)) || (req != $past(req)));
endmodule

// File: rtl/noc_router.sv
module noc_router
  import noc_pkg::*;
#(
  parameter int MESH_W      = 4,
  parameter int MESH_H      = 4,
  parameter int POS_X       = 1,
  parameter int POS_Y       = 1,
  parameter bit ROUTE_YX    = 1'b0,
  parameter int FLIT_W      = 36,
  parameter int FIFO_DEPTH  = 8,
  parameter bit CUT_THROUGH = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPORT-1:0]        in_valid,
  input  logic [NPORT*FLIT_W-1:0] in_data,
  output logic [NPORT-1:0]        in_ready,
  output logic [NPORT-1:0]        out_valid,
  output logic [NPORT*FLIT_W-1:0] out_data,
  input  logic [NPORT-1:0]        out_ready
);
  localparam int MAX_PKT = MAX_BODY + 1;
  localparam int IDX_W   = 3;
  localparam logic [NPORT-1:0] BUILT = {POS_X > 0, POS_X < MESH_W - 1,
                                        POS_Y > 0, POS_Y < MESH_H - 1, 1'b1};

  logic [FLIT_W-1:0] head      [NPORT];
  logic [NPORT-1:0]  route     [NPORT];
  logic [CNT_W-1:0]  body_left [NPORT];
  logic [NPORT-1:0]  sel       [NPORT];  // sel[o][i]: output o takes the head of input i
  logic [NPORT-1:0]  req       [NPORT];  // req[o][i]: input i holds a header for output o
  logic [NPORT-1:0]  empty, pop;

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      pop[i] = 1'b0;
      for (int o = 0; o < NPORT; o++) pop[i] = pop[i] | sel[o][i];
    end
  end

  always_comb begin
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        req[o][i] = BUILT[i] & ~empty[i] & (body_left[i] == '0) & route[i][o];
  end

  for (genvar gi = 0; gi < NPORT; gi++) begin : g_in
    if (BUILT[gi]) begin : g_on
      logic [NODE_W-1:0] dst;

      flit_fifo #(.W(FLIT_W), .DEPTH(FIFO_DEPTH), .CT(CUT_THROUGH), .MAX_PKT(MAX_PKT)) u_fifo (
        .clk(clk), .rst(rst),
        .wr_valid(in_valid[gi]), .wr_data(in_data[gi*FLIT_W +: FLIT_W]), .wr_ready(in_ready[gi]),
        .rd_pop(pop[gi]), .rd_data(head[gi]), .rd_empty(empty[gi])
      );

      assign dst = hdr_dst(head[gi][HDR_BITS-1:0]);

      route_unit #(.MESH_W(MESH_W), .POS_X(POS_X), .POS_Y(POS_Y), .YX(ROUTE_YX)) u_route (
        .dst(dst), .port_oh(route[gi])
      );

      always_ff @(posedge clk) begin
        if (rst) body_left[gi] <= '0;
        else if (pop[gi])
          body_left[gi] <= (body_left[gi] == '0) ? hdr_cnt(head[gi][HDR_BITS-1:0])
                                                 : body_left[gi] - 1'b1;
      end
    end else begin : g_off
      logic unused_in;
      assign unused_in     = ^{in_valid[gi], in_data[gi*FLIT_W +: FLIT_W]};
      assign in_ready[gi]  = 1'b0;
      assign head[gi]      = '0;
      assign empty[gi]     = 1'b1;
      assign route[gi]     = '0;
      assign body_left[gi] = '0;
    end
  end

  for (genvar go = 0; go < NPORT; go++) begin : g_out
    if (BUILT[go]) begin : g_on
      logic              lock_q, ov_q;
      logic [IDX_W-1:0]  owner_q, gidx;
      logic [FLIT_W-1:0] od_q, mux_flit;
      logic [NPORT-1:0]  grant, owner_oh;
      logic              space, take, serve, last_body;

      assign space     = ~ov_q | out_ready[go];
      assign take      = ~lock_q & space & (|req[go]);
      assign owner_oh  = NPORT'(1) << owner_q;
      assign serve     = lock_q & space & ~empty[owner_q];
      assign last_body = (body_left[owner_q] == CNT_W'(1));
      assign sel[go]   = take ? grant : (serve ? owner_oh : '0);

      rr_arbiter #(.N(NPORT)) u_arb (
        .clk(clk), .rst(rst), .req(req[go]), .advance(take), .grant(grant)
      );

      always_comb begin
        mux_flit = '0;
        gidx     = '0;
        for (int i = 0; i < NPORT; i++) begin
          if (sel[go][i]) mux_flit = mux_flit | head[i];
          if (grant[i])   gidx     = IDX_W'(i);
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          lock_q  <= 1'b0;
          owner_q <= '0;
          ov_q    <= 1'b0;
          od_q    <= '0;
        end else begin
          if (|sel[go]) begin
            ov_q <= 1'b1;
            od_q <= mux_flit;
          end else if (out_ready[go]) begin
            ov_q <= 1'b0;
          end
          if (take && hdr_cnt(mux_flit[HDR_BITS-1:0]) != '0) begin
            lock_q  <= 1'b1;
            owner_q <= gidx;
          end else if (serve && last_body) begin
            lock_q <= 1'b0;
          end
        end
      end

      assign out_valid[go]                 = ov_q;
      assign out_data[go*FLIT_W +: FLIT_W] = od_q;

      // R5
      lock_owner_chk: assert property (@(posedge clk) disable iff (rst)
        lock_q |-> body_left[owner_q] != '0);
      // R8
      hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid[go] && !out_ready[go]) |=> (out_valid[go] && $stable(out_data[go*FLIT_W +: FLIT_W])));
    end else begin : g_off
      logic unused_out;
      assign unused_out                    = out_ready[go] ^ (|req[go]);
      assign out_valid[go]                 = 1'b0;
      assign out_data[go*FLIT_W +: FLIT_W] = '0;
      assign sel[go]                       = '0;
    end
  end
endmodule

// File: tb/noc_router_bench.sv
module noc_router_bench;
  logic clk = 1'b0;
  logic rst;
  always #4 clk = ~clk;

  logic [4:0]   iv, ir, ov, ordy, civ, cir, cov, cordy;
  logic [179:0] id, od, cid, cod;

  noc_router u_noc_router (
    .clk(clk), .rst(rst), .in_valid(iv), .in_data(id), .in_ready(ir),
    .out_valid(ov), .out_data(od), .out_ready(ordy)
  );

  noc_router #(.POS_X(0), .POS_Y(0), .ROUTE_YX(1'b1), .FIFO_DEPTH(16), .CUT_THROUGH(1'b1))
  u_noc_router_corner (
    .clk(clk), .rst(rst), .in_valid(civ), .in_data(cid), .in_ready(cir),
    .out_valid(cov), .out_data(cod), .out_ready(cordy)
  );

  int checks = 0, fails = 0;
  logic [35:0] expq [25][$];
  int in_left [5], in_out [5], cur [5], left_o [5];
  bit rr_phase = 1'b0;
  int rr_src [$];
  int c_north = 0;
  string phase_req = "R6";

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [35:0] mk_hdr(int src, int dst, int cnt);
    return {13'h0A5, 3'(cnt), 10'(src), 10'(dst)};
  endfunction

  function automatic logic [35:0] mk_body(int src, int k);
    return {4'hB, 16'(k), 6'h0, 10'(src)};
  endfunction

  // XY reference for the router at (1,1) of a 4-wide mesh
  function automatic int ref_route(int dst);
    int dx = dst % 4, dy = dst / 4;
    if (dx > 1) return 3;
    if (dx < 1) return 4;
    if (dy > 1) return 1;
    if (dy < 1) return 2;
    return 0;
  endfunction

  task automatic model_in(int p, logic [35:0] f);
    if (in_left[p] == 0) begin
      in_out[p]  = ref_route(int'(f[9:0]));
      in_left[p] = int'(f[22:20]);
    end else begin
      in_left[p]--;
    end
    expq[in_out[p]*5 + p].push_back(f);
  endtask

  task automatic model_out(int o, logic [35:0] f);
    if (cur[o] < 0) begin
      int hit = -1;
      for (int i = 0; i < 5; i++)
        if (hit < 0 && expq[o*5+i].size() > 0 && expq[o*5+i][0] == f) hit = i;
      chk(hit >= 0, phase_req, $sformatf("unexpected header on port %0d", o), longint'(f), 0);
      if (hit >= 0) begin
        void'(expq[o*5+hit].pop_front());
        left_o[o] = int'(f[22:20]);
        cur[o]    = (left_o[o] > 0) ? hit : -1;
        if (o == 0 && rr_phase) rr_src.push_back(int'(f[19:10]));
      end
    end else begin
      logic [35:0] e;
      int q = o*5 + cur[o];
      e = (expq[q].size() > 0) ? expq[q][0] : 36'h0;
      chk(f == e, phase_req, $sformatf("body flit on port %0d", o), longint'(f), longint'(e));
      if (expq[q].size() > 0) void'(expq[q].pop_front());
      left_o[o]--;
      if (left_o[o] == 0) cur[o] = -1;
    end
  endtask

  initial begin
    for (int p = 0; p < 5; p++) begin
      in_left[p] = 0; in_out[p] = 0; cur[p] = -1; left_o[p] = 0;
    end
  end

  always begin
    @(negedge clk);
    #2;
    if (!rst) begin
      for (int p = 0; p < 5; p++)
        if (iv[p] && ir[p]) model_in(p, id[p*36 +: 36]);
      for (int o = 0; o < 5; o++)
        if (ov[o] && ordy[o]) model_out(o, od[o*36 +: 36]);
      if (cov[1] && cordy[1]) c_north++;
    end
  end

  task automatic push(bit c, int p, logic [35:0] d);
    if (c) begin civ[p] = 1'b1; cid[p*36 +: 36] = d; end
    else   begin iv[p]  = 1'b1; id[p*36 +: 36]  = d; end
    while (!(c ? cir[p] : ir[p])) begin
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    if (c) civ[p] = 1'b0; else iv[p] = 1'b0;
    @(negedge clk); #1;
  endtask

  task automatic send(bit c, int p, int src, int dst, int cnt);
    push(c, p, mk_hdr(src, dst, cnt));
    for (int k = 0; k < cnt; k++) push(c, p, mk_body(src, k));
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(150000 * 8);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [35:0] held;
    rst = 1'b1; iv = '0; civ = '0; id = '0; cid = '0; ordy = '1; cordy = '1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;

    // R11 reset state, R1 port set of the corner router
    chk(ov == 5'h00, "R11", "outputs after reset", ov, 0);
    chk(ir == 5'h1F, "R11", "central inputs ready", ir, 5'h1F);
    chk(cir == 5'b01011, "R1", "corner built inputs", cir, 5'b01011);
    chk(cov == 5'h00, "R1", "corner outputs idle", cov, 0);

    // R2 XY directions, R4 local delivery, R6 packet length from the header
    phase_req = "R2";
    send(0, 0, 16, 6, 2);
    send(0, 0, 16, 4, 1);
    send(0, 0, 16, 9, 0);
    send(0, 0, 16, 1, 3);
    send(0, 4, 20, 10, 1);
    send(0, 3, 19, 8, 0);
    phase_req = "R4";
    send(0, 0, 16, 5, 2);
    wait_cycles(10);

    // R5 two inputs race for the local output with long packets
    phase_req = "R5";
    fork
      send(0, 2, 18, 5, 5);
      send(0, 3, 19, 5, 5);
    join
    wait_cycles(15);

    // R7 round-robin between north and west behind a stalled output
    phase_req = "R7";
    ordy[0] = 1'b0;
    rr_phase = 1'b1;
    fork
      for (int k = 0; k < 4; k++) send(0, 1, 17, 5, 0);
      for (int k = 0; k < 4; k++) send(0, 4, 20, 5, 0);
    join
    ordy[0] = 1'b1;
    wait_cycles(15);
    rr_phase = 1'b0;
    chk(rr_src.size() == 8, "R7", "granted packets", rr_src.size(), 8);
    for (int k = 1; k < rr_src.size(); k++)
      chk(rr_src[k] != rr_src[k-1], "R7", "alternating source", rr_src[k], rr_src[k-1] ^ 1);

    // R12 back-pressure once the queue is full, R8 stalled output holds
    phase_req = "R12";
    ordy[3] = 1'b0;
    send(0, 0, 16, 6, 7);
    push(0, 0, mk_hdr(16, 6, 7));
    chk(ir[0] == 1'b0, "R12", "ready with full queue", ir[0], 0);
    held = od[3*36 +: 36];
    wait_cycles(3);
    chk(ov[3] == 1'b1, "R8", "stalled valid", ov[3], 1);
    chk(od[3*36 +: 36] == held, "R8", "stalled data", longint'(od[3*36 +: 36]), longint'(held));
    ordy[3] = 1'b1;
    for (int k = 0; k < 7; k++) push(0, 0, mk_body(16, k));
    wait_cycles(20);

    // R3 row before column on the corner router
    push(1, 0, mk_hdr(16, 5, 0));
    @(negedge clk); #1;
    chk(cov[1] == 1'b1 && cov[3] == 1'b0, "R3", "row first to north", cov, 5'b00010);
    chk(cod[1*36 +: 36] == mk_hdr(16, 5, 0), "R3", "north flit", longint'(cod[1*36 +: 36]),
        longint'(mk_hdr(16, 5, 0)));
    wait_cycles(3);
    push(1, 0, mk_hdr(16, 1, 0));
    @(negedge clk); #1;
    chk(cov[3] == 1'b1, "R3", "same row goes east", cov, 5'b01000);
    chk(cod[3*36 +: 36] == mk_hdr(16, 1, 0), "R3", "east flit", longint'(cod[3*36 +: 36]),
        longint'(mk_hdr(16, 1, 0)));
    wait_cycles(3);

    // R10 cut-through admission on the corner router
    c_north = 0;
    cordy[1] = 1'b0;
    send(1, 0, 16, 5, 7);
    push(1, 0, mk_hdr(16, 5, 7));
    for (int k = 0; k < 6; k++) push(1, 0, mk_body(16, k));
    chk(cir[0] == 1'b1, "R10", "body accepted with two free", cir[0], 1);
    push(1, 0, mk_body(16, 6));
    chk(cir[0] == 1'b0, "R10", "header refused with one free", cir[0], 0);
    cordy[1] = 1'b1;
    wait_cycles(25);
    chk(c_north == 16, "R10", "flits delivered north", c_north, 16);

    // R9 everything delivered in order, nothing left over
    for (int q = 0; q < 25; q++)
      chk(expq[q].size() == 0, "R9", $sformatf("queue %0d leftover", q), expq[q].size(), 0);

    summary();
    $finish;
  end
endmodule